// File: doc/BRIEF.md
# Dual Program-Counter Match Interrupt

This block watches the processor's 20-bit program counter and raises an interrupt request when it reaches one of two programmed addresses. It is used to set hardware breakpoints or to patch code held in read-only memory. Each of the two channels holds a 20-bit target address and has its own enable bit. A channel compares its target against the program counter only on cycles where the fetch strobe marks an instruction fetch. A hit produces a one-cycle request on that channel's output and on a combined output.

The requests do not pass through the global interrupt enable flag or the processor priority level. The block has no input for either, so nothing can mask a request except the channel's own enable bit. Software reaches the settings through a byte-wide register port. A write takes effect in the cycle it is presented. A read returns data combinationally for the address on the port. The port has no handshake and never stalls.

The register map works as follows:
- Address 09h holds the enable register. Bit 0 enables channel 0 and bit 1 enables channel 1.
- Channel 0's target occupies 10h to 12h, least significant byte first.
- Channel 1's target occupies 14h to 16h, least significant byte first.

Top module: `pc_match_irq`

## Requirements
- R1: After reset both enable bits read 0, both target registers read 0, and no request output is high.
- R2: At 09h, bit 0 enables channel 0 and bit 1 enables channel 1, where 1 means enabled. Bits 7 to 2 are discarded on write and read as 0.
- R3: Target bytes for channel 0 sit at 10h (bits 7:0), 11h (bits 15:8) and 12h (bits 19:16), and for channel 1 at 14h, 15h and 16h in the same order. A written byte reads back unchanged.
- R4: In the top byte of a target (12h, 16h), bits 7 to 4 are discarded on write and read as 0.
- R5: When the fetch strobe is high, the channel is enabled and the program counter equals the target, that channel's request is high in the following cycle for exactly one cycle per such fetch.
- R6: With the fetch strobe low, no request is raised, whatever the program counter value.
- R7: A channel whose enable bit is 0 never raises its request.
- R8: When both channels hit on the same fetch, both per-channel requests are high together. The combined request is high exactly when at least one per-channel request is high.
- R9: Writes to any address outside 09h, 10h to 12h and 14h to 16h change no register. Reads there return 0.
- R10: A register write in the same cycle as a fetch does not affect that fetch's comparison, which uses the settings held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| fetch_vld | input | 1 | High on a cycle carrying an instruction fetch |
| fetch_pc | input | 20 | Program counter of the fetch |
| match_irq | output | 2 | Per-channel request, bit i for channel i |
| match_irq_any | output | 1 | OR of the per-channel requests |

## Verification
A corrupted target or enable bit shows at once on reg_rdata for its byte address. It also shows on match_irq one cycle after the next fetch whose program counter meets the affected channel. A comparator that holds state wrongly shows as a request lasting past one cycle or appearing without a fetch, visible on the cycle after. The bench runs a behavioural model alongside the design and compares both the request outputs and the read data on every clock. A fault therefore shows no later than one cycle after it has any visible effect.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  // Byte layout of the register port
  localparam int BYTE_W    = 8;
  localparam int EN_OFS    = 'h09;
  localparam int CH_BASE   = 'h10;
  localparam int CH_STRIDE = 4;

  function automatic int bytes_for(input int bits);
    return (bits + BYTE_W - 1) / BYTE_W;
  endfunction
endpackage

// File: rtl/pcm_regs.sv
module pcm_regs
  import pcm_pkg::*;
#(
  parameter int PC_W   = 20,
  parameter int NUM_CH = 2,
  parameter int BUS_AW = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reg_wr,
  input  logic [BUS_AW-1:0]             reg_addr,
  input  logic [BYTE_W-1:0]             reg_wdata,
  output logic [BYTE_W-1:0]             reg_rdata,
  output logic [NUM_CH-1:0]             en_q,
  output logic [NUM_CH-1:0][PC_W-1:0]   addr_q
);
  localparam int NB    = bytes_for(PC_W);
  localparam int PAD_W = NB * BYTE_W;
  localparam logic [PAD_W-1:0] KEEP = PAD_W'({PC_W{1'b1}});

  logic [NUM_CH-1:0][PAD_W-1:0] pad_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      pad_q <= '0;
    end else if (reg_wr) begin
      if (reg_addr == BUS_AW'(EN_OFS))
        en_q <= reg_wdata[NUM_CH-1:0];
      for (int ch = 0; ch < NUM_CH; ch++)
        for (int b = 0; b < NB; b++)
          if (reg_addr == BUS_AW'(CH_BASE + CH_STRIDE*ch + b))
            pad_q[ch][b*BYTE_W +: BYTE_W] <= reg_wdata & KEEP[b*BYTE_W +: BYTE_W];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == BUS_AW'(EN_OFS))
      reg_rdata = BYTE_W'(en_q);
    for (int ch = 0; ch < NUM_CH; ch++)
      for (int b = 0; b < NB; b++)
        if (reg_addr == BUS_AW'(CH_BASE + CH_STRIDE*ch + b))
          reg_rdata = pad_q[ch][b*BYTE_W +: BYTE_W];
  end

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_out
      assign addr_q[g] = pad_q[g][PC_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/pcm_cmp.sv
module pcm_cmp #(
  parameter int PC_W = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fetch_vld,
  input  logic [PC_W-1:0] fetch_pc,
  input  logic [PC_W-1:0] target,
  input  logic            enable,
  output logic            hit_d,
  output logic            hit_q
);
  assign hit_d = fetch_vld && enable && (fetch_pc == target);

  always_ff @(posedge clk) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= hit_d;
  end
endmodule

// File: rtl/pc_match_irq.sv
module pc_match_irq #(
  parameter int PC_W   = 20,
  parameter int NUM_CH = 2,
  parameter int BUS_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [BUS_AW-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              fetch_vld,
  input  logic [PC_W-1:0]   fetch_pc,
  output logic [NUM_CH-1:0] match_irq,
  output logic              match_irq_any
);
  logic [NUM_CH-1:0]           en_q;
  logic [NUM_CH-1:0][PC_W-1:0] addr_q;
  logic [NUM_CH-1:0]           hit_d;
  logic                        any_q;

  pcm_regs #(.PC_W(PC_W), .NUM_CH(NUM_CH), .BUS_AW(BUS_AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .en_q      (en_q),
    .addr_q    (addr_q)
  );

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      pcm_cmp #(.PC_W(PC_W)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .fetch_vld (fetch_vld),
        .fetch_pc  (fetch_pc),
        .target    (addr_q[g]),
        .enable    (en_q[g]),
        .hit_d     (hit_d[g]),
        .hit_q     (match_irq[g])
      );
    end
  endgenerate

  // Combined request kept in its own flop so it leaves with the per-channel ones
  always_ff @(posedge clk) begin
    if (!rst_n) any_q <= 1'b0;
    else        any_q <= |hit_d;
  end
  assign match_irq_any = any_q;
endmodule

// File: rtl/pcm_chk.sv
module pcm_chk #(
  parameter int PC_W   = 20,
  parameter int NUM_CH = 2
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        fetch_vld,
  input logic [PC_W-1:0]             fetch_pc,
  input logic [NUM_CH-1:0]           en_q,
  input logic [NUM_CH-1:0][PC_W-1:0] addr_q,
  input logic [NUM_CH-1:0]           match_irq,
  input logic                        match_irq_any
);
  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_vld |=> (match_irq == '0));

  // R8
  any_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_irq_any == (match_irq != '0));

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
      // R5
      hit_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_vld && en_q[g] && fetch_pc == addr_q[g]) |=> match_irq[g]);
      // R7
      off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_vld && !en_q[g]) |=> !match_irq[g]);
      // R5
      pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_irq[g] |-> $past(fetch_vld));
    end
  endgenerate
endmodule

bind pc_match_irq pcm_chk #(.PC_W(PC_W), .NUM_CH(NUM_CH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .fetch_vld     (fetch_vld),
  .fetch_pc      (fetch_pc),
  .en_q          (en_q),
  .addr_q        (addr_q),
  .match_irq     (match_irq),
  .match_irq_any (match_irq_any)
);

// File: tb/pc_match_irq_bench.sv
module pc_match_irq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        fetch_vld = 1'b0;
  logic [19:0] fetch_pc = '0;
  logic [1:0]  match_irq;
  logic        match_irq_any;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pc_match_irq u_pc_match_irq (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fetch_vld(fetch_vld),
    .fetch_pc(fetch_pc), .match_irq(match_irq), .match_irq_any(match_irq_any)
  );

  // Behavioural reference
  bit [1:0]  en_m;
  bit [23:0] tgt_m [2];
  bit [1:0]  exp_irq;
  bit        exp_any;

  function automatic bit [7:0] model_rd(input bit [7:0] a);
    if (a == 8'h09) return {6'b0, en_m};
    for (int c = 0; c < 2; c++)
      for (int b = 0; b < 3; b++)
        if (a == 8'(8'h10 + 4*c + b)) return tgt_m[c][b*8 +: 8];
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      en_m = '0; tgt_m[0] = '0; tgt_m[1] = '0; exp_irq = '0; exp_any = 0;
    end else begin
      for (int c = 0; c < 2; c++)
        exp_irq[c] = fetch_vld && en_m[c] && (fetch_pc == tgt_m[c][19:0]);
      exp_any = |exp_irq;
      if (reg_wr) begin
        if (reg_addr == 8'h09) en_m = reg_wdata[1:0];
        for (int c = 0; c < 2; c++)
          for (int b = 0; b < 3; b++)
            if (reg_addr == 8'(8'h10 + 4*c + b))
              tgt_m[c][b*8 +: 8] = (b == 2) ? (reg_wdata & 8'h0F) : reg_wdata;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Per-clock comparison against the model (R5 R6 R7 R8 R3)
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk("R5 per-channel request", match_irq, exp_irq);
      chk("R8 combined request", match_irq_any, exp_any);
      chk("R3 read data", reg_rdata, model_rd(reg_addr));
    end
  end

  task automatic cyc(input bit wr, input bit [7:0] a, input bit [7:0] d,
                     input bit f, input bit [19:0] pc);
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = d; fetch_vld = f; fetch_pc = pc;
  endtask

  task automatic wr(input bit [7:0] a, input bit [7:0] d);
    cyc(1, a, d, 0, '0);
  endtask

  task automatic rd(input bit [7:0] a, input bit [7:0] e, input string tag);
    cyc(0, a, 0, 0, '0);
    #2 chk(tag, reg_rdata, e);
  endtask

  task automatic set_tgt(input int c, input bit [19:0] v);
    wr(8'(8'h10 + 4*c), v[7:0]);
    wr(8'(8'h11 + 4*c), v[15:8]);
    wr(8'(8'h12 + 4*c), {4'h0, v[19:16]});
  endtask

  // fetch, then check the request on the cycle after, then its end
  task automatic fetch_chk(input bit [19:0] pc, input bit f, input bit [1:0] e, input string tag);
    cyc(0, 0, 0, f, pc);
    cyc(0, 0, 0, 0, '0);
    #2 chk(tag, {match_irq_any, match_irq}, {|e, e});
    cyc(0, 0, 0, 0, '0);
    #2 chk("R5 single-cycle pulse", {match_irq_any, match_irq}, 3'b000);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    #2 chk("R1 requests after reset", {match_irq_any, match_irq}, 3'b000);
    rd(8'h09, 8'h00, "R1 enable after reset");
    rd(8'h12, 8'h00, "R1 target after reset");
    // R2 enable bits
    wr(8'h09, 8'hFF);
    rd(8'h09, 8'h03, "R2 enable readback");
    // R3 target byte layout
    set_tgt(0, 20'h12345);
    set_tgt(1, 20'hABCDE);
    rd(8'h10, 8'h45, "R3 ch0 low byte");
    rd(8'h11, 8'h23, "R3 ch0 mid byte");
    rd(8'h12, 8'h01, "R3 ch0 top byte");
    rd(8'h14, 8'hDE, "R3 ch1 low byte");
    rd(8'h16, 8'h0A, "R3 ch1 top byte");
    // R4 upper nibble discarded
    wr(8'h12, 8'hF1);
    rd(8'h12, 8'h01, "R4 top nibble");
    // R9 unmapped addresses
    wr(8'h13, 8'h55);
    wr(8'h0A, 8'h77);
    wr(8'h08, 8'h00);
    rd(8'h13, 8'h00, "R9 unmapped read");
    rd(8'h09, 8'h03, "R9 enable untouched");
    rd(8'h10, 8'h45, "R9 target untouched");
    // R5 hit on channel 0
    fetch_chk(20'h12345, 1, 2'b01, "R5 channel 0 hit");
    fetch_chk(20'hABCDE, 1, 2'b10, "R5 channel 1 hit");
    fetch_chk(20'h12346, 1, 2'b00, "R5 near miss");
    // R6 no fetch strobe
    fetch_chk(20'h12345, 0, 2'b00, "R6 strobe low");
    // R8 both channels at once
    set_tgt(1, 20'h12345);
    fetch_chk(20'h12345, 1, 2'b11, "R8 both hit");
    // R7 disabled channels
    wr(8'h09, 8'h01);
    fetch_chk(20'h12345, 1, 2'b01, "R7 channel 1 off");
    wr(8'h09, 8'h00);
    fetch_chk(20'h12345, 1, 2'b00, "R7 both off");
    // R10 write coinciding with fetch
    wr(8'h09, 8'h03);
    cyc(1, 8'h10, 8'h00, 1, 20'h12345);
    cyc(0, 0, 0, 0, '0);
    #2 chk("R10 old target used", match_irq, 2'b11);
    fetch_chk(20'h12345, 1, 2'b10, "R10 new target after");
    // Random phase, checked every clock against the model
    for (int i = 0; i < 3000; i++) begin
      bit [7:0] a;
      bit [19:0] pc;
      case ($urandom_range(0, 9))
        0: a = 8'h09; 1: a = 8'h10; 2: a = 8'h11; 3: a = 8'h12;
        4: a = 8'h14; 5: a = 8'h15; 6: a = 8'h16; 7: a = 8'h13;
        default: a = 8'($urandom);
      endcase
      pc = ($urandom_range(0, 1) == 1) ? tgt_m[$urandom_range(0, 1)][19:0] : 20'($urandom);
      cyc($urandom_range(0, 3) == 0, a, 8'($urandom_range(0, 3) == 0 ? 0 : $urandom),
          $urandom_range(0, 1) == 1, pc);
    end
    cyc(0, 0, 0, 0, '0);
    repeat (2) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    done = 1;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule